// File: doc/BRIEF.md
# Look-Ahead Gray-Code Counter

This block is a synchronous up-counter that keeps its state directly in reflected Gray code. On every enabled clock edge the count moves to the next Gray code, and exactly one output bit changes. It is meant to be the shared code counter of a multi-channel ramp converter. Each channel latches the count at the moment its comparator trips. Because only one bit moves per step, a latch that closes mid-transition can only capture a neighbouring code, never a wild value.

Each bit's toggle decision is made by a look-ahead network over the lower bits. A small parity flop flips on every count. Bit 0 toggles on even parity. Every higher bit toggles on odd parity when the bit just below it is 1 and all the bits below that are 0. The "all lower bits zero" terms come from a grouped zero-detect prefix, not from a serial chain. No logic runs from the most significant bit back into the decisions for the low bits.

Top module: `gray_code_counter`

## Requirements
- R1: After the asynchronous reset rst_ni is released, count_o is all zeros and tc_o is low.
- R2: On every clock edge with cnt_en_i high and clr_i low, count_o changes in exactly one bit position.
- R3: Decoding count_o from Gray to binary (bit i of the binary value is the XOR of Gray bits i and above), each enabled edge raises the binary value by exactly one, modulo 2^WIDTH.
- R4: From the final code, the Gray code of 2^WIDTH-1 (only the top bit set, 0x800 for WIDTH=12), the next enabled edge returns count_o to zero.
- R5: tc_o is high exactly when count_o equals the final code of R4.
- R6: While cnt_en_i is low, count_o does not change, and the hidden parity is held too. Counting that resumes after a pause at any code continues the R3 sequence.
- R7: With clr_i high, a clock edge sets count_o to zero and resets the parity, whatever cnt_en_i is. Counting then restarts from binary value 0.
- R8: One full period covers 2^WIDTH distinct codes, and every 12-bit code appears once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of count and parity |
| cnt_en_i | input | 1 | Count enable |
| count_o | output | WIDTH | Gray-code count |
| tc_o | output | 1 | Terminal-count flag (final code present) |

## Verification
The main stimulus is an unbroken run of enabled edges through two full periods. Decoding every step separates a wrong toggle choice, which breaks the single-bit rule or the +1 rule, from a faulty wrap at the top. A second pattern gates the enable on and off in an irregular rhythm, with pauses at both odd and even parity. Only a correctly held parity flop keeps the sequence intact there. A third pattern raises clear with enable both high and low, mid-count at an odd value. This shows that clear wins over enable and that it resets the parity as well as the visible bits.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  // Gray code of the largest binary value: only the top bit set
  function automatic logic [31:0] last_code(input int unsigned w);
    logic [31:0] r;
    r = '0;
    r[w-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/gray_zero_lookahead.sv
// low_zero_o[i] = 1 when bits [i-1:0] of the state are all zero.
// Group zero flags are combined by a prefix so depth grows with W/GROUP.
module gray_zero_lookahead #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] state_i,
  output logic [WIDTH-1:0] low_zero_o
);
  localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;

  logic [NGRP-1:0] grp_zero;
  logic [NGRP:0]   grp_pre;

  always_comb begin
    for (int g = 0; g < int'(NGRP); g++) begin
      grp_zero[g] = 1'b1;
      for (int b = 0; b < int'(GROUP); b++) begin
        if (g * int'(GROUP) + b < int'(WIDTH))
          grp_zero[g] = grp_zero[g] & ~state_i[g*int'(GROUP)+b];
      end
    end
    grp_pre[0] = 1'b1;
    for (int g = 0; g < int'(NGRP); g++) grp_pre[g+1] = grp_pre[g] & grp_zero[g];
  end

  for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
    localparam int unsigned GI = i / GROUP;
    localparam int unsigned BASE = GI * GROUP;
    if (i == int'(BASE)) begin : g_aligned
      assign low_zero_o[i] = grp_pre[GI];
    end else begin : g_partial
      assign low_zero_o[i] = grp_pre[GI] & ~(|state_i[i-1:BASE]);
    end
  end
endmodule

// File: rtl/gray_toggle_gen.sv
module gray_toggle_gen #(
  parameter int unsigned WIDTH = 12
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] low_zero_i,
  input  logic             parity_i,
  output logic [WIDTH-1:0] toggle_o
);
  assign toggle_o[0] = ~parity_i;

  for (genvar i = 1; i < int'(WIDTH) - 1; i++) begin : g_mid
    assign toggle_o[i] = parity_i & state_i[i-1] & low_zero_i[i-1];
  end

  // top bit: ignore bit W-2 so the last code wraps to zero
  if (WIDTH > 1) begin : g_top
    assign toggle_o[WIDTH-1] = parity_i & low_zero_i[WIDTH-2];
  end
endmodule

// File: rtl/gray_state_reg.sv
module gray_state_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  input  logic [WIDTH-1:0] toggle_i,
  output logic [WIDTH-1:0] state_o,
  output logic             parity_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= '0;
      parity_o <= 1'b0;
    end else if (clr_i) begin
      state_o  <= '0;
      parity_o <= 1'b0;
    end else if (cnt_en_i) begin
      state_o  <= state_o ^ toggle_i;
      parity_o <= ~parity_o;
    end
  end
endmodule

// File: rtl/gray_code_counter.sv
module gray_code_counter
  import gray_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned GROUP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cnt_en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam logic [31:0] LAST32 = last_code(WIDTH);
  localparam logic [WIDTH-1:0] LAST = LAST32[WIDTH-1:0];

  logic [WIDTH-1:0] state, low_zero, toggle;
  logic             parity;

  gray_zero_lookahead #(.WIDTH(WIDTH), .GROUP(GROUP)) u_zero (
    .state_i    (state),
    .low_zero_o (low_zero)
  );

  gray_toggle_gen #(.WIDTH(WIDTH)) u_tgl (
    .state_i    (state),
    .low_zero_i (low_zero),
    .parity_i   (parity),
    .toggle_o   (toggle)
  );

  gray_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .cnt_en_i (cnt_en_i),
    .toggle_i (toggle),
    .state_o  (state),
    .parity_o (parity)
  );

  assign count_o = state;
  assign tc_o    = (state == LAST);
endmodule

// File: rtl/gray_code_counter_chk.sv
module gray_code_counter_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             cnt_en_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2: one bit per enabled step
  assert_one_bit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(cnt_en_i) && !$past(clr_i)) |-> $countones(count_o ^ $past(count_o)) == 1);

  // R6: hold when disabled
  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(cnt_en_i) && !$past(clr_i)) |-> $stable(count_o));

  // R7: clear wins
  assert_clear_to_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(clr_i)) |-> count_o == '0);

  // R4: wrap from final code
  assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(tc_o) && $past(cnt_en_i) && !$past(clr_i)) |-> count_o == '0);

  // R5: flag tracks final code
  assert_tc_matches_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o == (count_o == (WIDTH'(1) << (WIDTH-1))));
endmodule

bind gray_code_counter gray_code_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .cnt_en_i (cnt_en_i),
  .count_o  (count_o),
  .tc_o     (tc_o)
);

// File: tb/gray_code_counter_tb.sv
`timescale 1ns/1ps
module gray_code_counter_tb_top;
  localparam int W = 12;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] cnt;
  logic tc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gray_code_counter #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .cnt_en_i(en),
    .count_o(cnt), .tc_o(tc)
  );

  function automatic int decode(input logic [W-1:0] g);
    int b = 0;
    logic acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = acc ^ g[i];
      if (acc) b = b | (1 << i);
    end
    return b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge, then sample 1 ns later
  task automatic tick(input logic e, input logic c);
    en = e;
    clr = c;
    @(posedge clk);
    #1;
  endtask

  bit seen[N];

  initial begin
    logic [W-1:0] prev;
    int exp_v;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    check("R1 count", int'(cnt), 0);
    check("R1 tc", int'(tc), 0);

    // two full periods, every step checked
    exp_v = 0;
    for (int i = 0; i < 2 * N; i++) begin
      prev = cnt;
      if (i < N) seen[decode(cnt)] = 1'b1;
      check("R5 tc", int'(tc), int'(exp_v == N - 1));
      tick(1'b1, 1'b0);
      exp_v = (exp_v + 1) % N;
      check("R2 onebit", $countones(cnt ^ prev), 1);
      check("R3 incr", decode(cnt), exp_v);
      if (decode(prev) == N - 1) check("R4 wrap", int'(cnt), 0);
    end
    begin
      int miss = 0;
      for (int k = 0; k < N; k++) if (!seen[k]) miss++;
      check("R8 coverage", miss, 0);
    end

    // gated enable, pauses at odd and even parity
    for (int i = 0; i < 3000; i++) begin
      logic e;
      e = ((i % 7) < 3) || ((i % 5) == 4);
      prev = cnt;
      tick(e, 1'b0);
      if (e) exp_v = (exp_v + 1) % N;
      else check("R6 hold", int'(cnt), int'(prev));
      check("R6 seq", decode(cnt), exp_v);
    end

    // clear at odd value, with enable high and low
    while (exp_v % 2 == 0) begin tick(1'b1, 1'b0); exp_v = (exp_v + 1) % N; end
    tick(1'b1, 1'b1);
    check("R7 clr en", int'(cnt), 0);
    for (int i = 1; i <= 5; i++) begin
      tick(1'b1, 1'b0);
      check("R7 restart", decode(cnt), i);
    end
    tick(1'b0, 1'b1);
    check("R7 clr idle", int'(cnt), 0);
    tick(1'b1, 1'b0);
    check("R7 after", decode(cnt), 1);

    // async reset mid-count
    tick(1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R1 async", int'(cnt), 0);
    en = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule